// File: doc/BRIEF.md
# Toggle-Cleared Watchdog Timer

This block watches a single heartbeat pin driven by a processor. Software proves it is alive by changing the level of that pin: a rising change and a falling change each count. Every accepted change restarts a timeout counter. If the counter reaches its limit before another change arrives, the active-low watchdog output goes low. It stays low until the next accepted change brings it high again.

The heartbeat pin is brought into the clock domain by a synchroniser. It then passes through a persistence filter, so that level changes shorter than a set number of cycles count as noise. The block also takes two status inputs from a companion reset generator. While the system reset is active, the counter is held at zero. Counting resumes by itself once that reset falls. An undervoltage flag pulls the output low at once, whether or not a timeout has happened. A disable input stands in for detecting a floated or undriven heartbeat pin; while it is high the counter is held at zero. All times are parameters in clock cycles.

Top module: `toggle_watchdog`

## Requirements
- R1: A level change on `kick_i` that survives the filter clears the timeout counter, whichever direction it goes. The counter is cleared at the (FILT_CYC+SYNC_STAGES)-th rising clock edge after the first edge that samples the new level.
- R2: If TIMEOUT_CYC consecutive clock edges pass with no clearing event, `wdo_n` goes low after the last of them. It then stays low until a clearing event occurs.
- R3: While `uv_i` is 1, `wdo_n` is 0 in the same cycle, whatever the state of the counter.
- R4: While `sys_rst_i` is 1, the counter is held at zero and no timeout can occur. Counting restarts on the first edge after it returns to 0, so a timeout needs TIMEOUT_CYC further quiet edges.
- R5: A level on `kick_i` that lasts fewer than FILT_CYC synchronised cycles before returning has no effect: the timeout still fires at the time it would have without that pulse. A level held for FILT_CYC cycles or longer is accepted.
- R6: While `disable_i` is 1, the counter is held at zero and `wdo_n` follows only `uv_i`.
- R7: After `rst_n` is released, `wdo_n` is 1 (with `uv_i` at 0), the accepted heartbeat level is 0, and the counter starts from zero.
- R8: After a timeout, the next accepted level change on `kick_i` returns `wdo_n` to 1 on the same edge that clears the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick_i | input | 1 | Heartbeat pin from the processor, asynchronous |
| disable_i | input | 1 | 1 disables supervision (heartbeat pin undriven) |
| sys_rst_i | input | 1 | 1 while the companion reset generator holds system reset |
| uv_i | input | 1 | 1 while the supply is below the reset threshold |
| wdo_n | output | 1 | Active-low watchdog output |

## Verification
The hardest situation to reach is the filter boundary. A heartbeat pulse one cycle shorter than the persistence length must leave the timeout schedule unchanged. A pulse of exactly that length must produce two accepted changes, one for each edge of the pulse. The stimulus stops regular toggling and then sends pulses of widths FILT_CYC-1 and FILT_CYC at chosen points inside a quiet window. The per-edge reference model then decides whether the output falls on the original timeout edge or on a later one. The reset-hold and disable phases are entered with the counter already close to its limit, so that a counter that failed to hold would fire within the window.

// File: rtl/wdt_pkg.sv
// Package: shared defaults and helpers for the toggle-cleared watchdog.
// Assumes a 250 MHz clock for the default cycle counts.
package wdt_pkg;
    // Default timeout: 1.6 s at 250 MHz
    localparam int unsigned DEF_TIMEOUT_CYC = 400_000_000;
    // Default persistence: 20 ns at 250 MHz
    localparam int unsigned DEF_FILT_CYC    = 5;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Width needed to hold values 0..n
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/wdt_edge_filter.sv
// Module: wdt_edge_filter
// Synchronises the asynchronous heartbeat pin. A new level is accepted only
// after it has been seen for FILT_CYC consecutive synchronised cycles. A
// one-cycle pulse is emitted for every accepted level change, in either direction.
// Assumes SYNC_STAGES >= 2 and FILT_CYC >= 1.
module wdt_edge_filter
    import wdt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned FILT_CYC    = DEF_FILT_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic toggle_o
);
    localparam int unsigned FW = cnt_width(FILT_CYC);
    localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic                   level_q;
    logic [FW-1:0]          run_q;
    logic                   accept;

    // Synchroniser shift chain toward the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    assign synced = sync_q[SYNC_STAGES-1];
    assign accept = (synced != level_q) && (run_q == LAST);

    // Persistence counter: counts how long the synchronised level has differed
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_q <= '0;
        else if (synced == level_q) run_q <= '0;
        else if (accept)            run_q <= '0;
        else                        run_q <= run_q + 1'b1;
    end

    // Accepted level and the one-cycle change pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q  <= 1'b0;
            toggle_o <= 1'b0;
        end else begin
            toggle_o <= accept;
            if (accept) level_q <= synced;
        end
    end
endmodule

// File: rtl/wdt_timer.sv
// Module: wdt_timer
// Counts quiet cycles and latches an expiry flag after TIMEOUT_CYC edges with
// no clear. Any clear request zeroes both the count and the flag.
// Assumes TIMEOUT_CYC >= 2.
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = DEF_TIMEOUT_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic expired_o
);
    localparam int unsigned TW = cnt_width(TIMEOUT_CYC);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC - 1);

    logic [TW-1:0] cnt_q;

    // Quiet-cycle counter that stops at its limit and sets the expiry flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            expired_o <= 1'b0;
        end else if (clear_i) begin
            cnt_q     <= '0;
            expired_o <= 1'b0;
        end else if (cnt_q == LIMIT) begin
            expired_o <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/toggle_watchdog.sv
// Module: toggle_watchdog (top)
// Supervises a processor heartbeat pin. Accepted level changes clear the timer.
// System reset and the disable input hold the timer cleared. The output is low
// on expiry or while undervoltage is flagged.
// Assumes sys_rst_i, uv_i and disable_i are already synchronous to clk.
module toggle_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = DEF_TIMEOUT_CYC,
    parameter int unsigned FILT_CYC    = DEF_FILT_CYC,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic disable_i,
    input  logic sys_rst_i,
    input  logic uv_i,
    output logic wdo_n
);
    logic kick_toggle;
    logic expired;
    logic timer_clear;

    wdt_edge_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_CYC   (FILT_CYC)
    ) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (kick_i),
        .toggle_o(kick_toggle)
    );

    // Any hold condition or accepted heartbeat clears the timer
    assign timer_clear = kick_toggle | sys_rst_i | disable_i;

    wdt_timer #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (timer_clear),
        .expired_o(expired)
    );

    // Output low on expiry or on undervoltage
    assign wdo_n = ~(expired | uv_i);
endmodule

// File: rtl/wdt_checker.sv
// Module: wdt_checker
// Temporal properties of toggle_watchdog, attached to it with bind.
module wdt_checker (
    input logic clk,
    input logic rst_n,
    input logic disable_i,
    input logic sys_rst_i,
    input logic uv_i,
    input logic wdo_n,
    input logic tgl,
    input logic exp_q
);
    // R1: an accepted change leaves the timer unexpired
    a_r1_toggle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tgl |=> !exp_q);

    // R2: expiry begins only after an edge with no hold request
    a_r2_rise_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exp_q) |-> (!$past(sys_rst_i) && !$past(disable_i) && !$past(tgl)));

    // R2: once expired, it stays expired until cleared
    a_r2_expiry_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_q && !tgl && !sys_rst_i && !disable_i) |=> exp_q);

    // R3: undervoltage forces the output low
    a_r3_uv_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |-> !wdo_n);

    // R4: system reset leaves the output following only undervoltage
    a_r4_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_i |=> (wdo_n == !uv_i));

    // R6: disable leaves the output following only undervoltage
    a_r6_disable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> (wdo_n == !uv_i));
endmodule

bind toggle_watchdog wdt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .disable_i(disable_i),
    .sys_rst_i(sys_rst_i),
    .uv_i     (uv_i),
    .wdo_n    (wdo_n),
    .tgl      (kick_toggle),
    .exp_q    (expired)
);

// File: tb/tb_toggle_watchdog.sv
`timescale 1ns/1ps
module tb_toggle_watchdog;
    localparam int TO   = 40;
    localparam int FILT = 3;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick_i = 1'b0;
    logic disable_i = 1'b0;
    logic sys_rst_i = 1'b0;
    logic uv_i = 1'b0;
    logic wdo_n;

    int checks = 0;
    int fails = 0;
    string cur_req = "R7";
    bit done = 1'b0;

    always #2 clk = ~clk;

    toggle_watchdog #(.TIMEOUT_CYC(TO), .FILT_CYC(FILT), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .disable_i(disable_i),
        .sys_rst_i(sys_rst_i), .uv_i(uv_i), .wdo_n(wdo_n)
    );

    // Reference model state, updated once per edge
    bit hist[$];
    bit m_level, m_pending, m_expired;
    int m_diff_run, m_quiet;

    task automatic check(input logic actual, input logic expected, input string what);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b t=%0t", cur_req, what, actual, expected, $time);
        end
    endtask

    // Behavioural model: heartbeat history, persistence run, quiet-cycle count
    always begin
        @(posedge clk);
        #1;
        if (!rst_n) begin
            hist.delete();
            m_level = 0; m_pending = 0; m_expired = 0;
            m_diff_run = 0; m_quiet = 0;
        end else begin
            bit seen, hold;
            seen = (hist.size() >= SYNC) ? hist[hist.size()-SYNC] : 1'b0;
            hold = m_pending || sys_rst_i || disable_i;
            m_pending = 0;
            if (seen == m_level) m_diff_run = 0;
            else if (m_diff_run == FILT-1) begin
                m_level = seen; m_diff_run = 0; m_pending = 1;
            end else m_diff_run++;
            if (hold) begin m_quiet = 0; m_expired = 0; end
            else if (m_quiet == TO-1) m_expired = 1;
            else m_quiet++;
            hist.push_back(kick_i);
            if (hist.size() > 8) void'(hist.pop_front());
        end
        check(wdo_n, !(m_expired || uv_i), "wdo_n vs model");
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flip();
        @(negedge clk);
        kick_i = ~kick_i;
    endtask

    task automatic pulse(input int w);
        @(negedge clk); kick_i = ~kick_i;
        wait_cyc(w);
        kick_i = ~kick_i;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R7: reset state
        cur_req = "R7";
        wait_cyc(4);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(1);
        check(wdo_n, 1'b1, "wdo_n after reset");

        // R1: regular toggling, both directions, prevents timeout
        cur_req = "R1";
        for (int i = 0; i < 20; i++) begin flip(); wait_cyc(10); end
        check(wdo_n, 1'b1, "no timeout under toggling");

        // R2: stop toggling until timeout
        cur_req = "R2";
        wait_cyc(TO + 10);
        check(wdo_n, 1'b0, "timeout reached");

        // R8: one toggle recovers the output
        cur_req = "R8";
        flip();
        wait_cyc(SYNC + FILT + 2);
        check(wdo_n, 1'b1, "recovered after toggle");

        // R5: short pulses ignored, pulses at the limit accepted
        cur_req = "R5";
        wait_cyc(30);
        pulse(FILT - 1);
        wait_cyc(5);
        pulse(1);
        wait_cyc(TO);
        check(wdo_n, 1'b0, "short pulses did not clear");
        pulse(FILT);
        wait_cyc(SYNC + FILT + 2);
        check(wdo_n, 1'b1, "pulse of limit width accepted");
        wait_cyc(TO + 10);

        // R3: undervoltage forces low, with and without expiry
        cur_req = "R3";
        flip(); wait_cyc(10);
        @(negedge clk) uv_i = 1'b1;
        wait_cyc(1);
        check(wdo_n, 1'b0, "uv forces low");
        @(negedge clk) uv_i = 1'b0;
        wait_cyc(2);

        // R4: system reset holds timer cleared near its limit
        cur_req = "R4";
        wait_cyc(TO - 15);
        @(negedge clk) sys_rst_i = 1'b1;
        wait_cyc(3 * TO);
        check(wdo_n, 1'b1, "held during system reset");
        @(negedge clk) uv_i = 1'b1;
        wait_cyc(3);
        @(negedge clk) uv_i = 1'b0;
        @(negedge clk) sys_rst_i = 1'b0;
        wait_cyc(TO - 3);
        check(wdo_n, 1'b1, "restart counts from zero");
        wait_cyc(10);
        check(wdo_n, 1'b0, "timeout after reset release");

        // R6: disable clears and holds
        cur_req = "R6";
        @(negedge clk) disable_i = 1'b1;
        wait_cyc(3 * TO);
        check(wdo_n, 1'b1, "held while disabled");
        pulse(1);
        wait_cyc(5);
        @(negedge clk) disable_i = 1'b0;
        wait_cyc(TO + 5);
        check(wdo_n, 1'b0, "timeout after enable");

        // R1: mixed spacing, close to the limit each time
        cur_req = "R1";
        for (int i = 0; i < 6; i++) begin flip(); wait_cyc(TO - FILT - 6); end
        wait_cyc(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule